// File: doc/BRIEF.md
# Two-Edge Separation Timer

This block measures how far apart rising edges on two independent inputs are, in timebase ticks. A rising edge on the start input opens an interval, and the next rising edge on the stop input closes it. The tick count of that interval is the *first separation*. The block also measures the reverse interval, from a stop edge to the next start edge, which is the *second separation*. It reports that value when the start edge arrives. Both inputs, and an optional external timebase, are asynchronous to the block clock and are synchronised internally. When the external timebase is not selected, the timebase is one tick per clock.

Each result leaves in one of two ways, selected by configuration:

- **Single mode:** the result is written to a pair of result registers that software can read.
- **Buffered mode:** the result is sent as one beat on a valid/ready stream toward an external buffer.
  - A beat carries both separation fields, each with its own present flag.
  - One beat can therefore report a second separation and a first separation that close in the same cycle.

Counts saturate at the all-ones value of the counter width. Each field carries an overflow flag.

Top module: `two_edge_sep_timer`

## Requirements
- R1: Only rising edges of `start_in` and `stop_in` act. A level held high for many cycles counts as one event at its rising edge.
- R2: The first separation is the number of timebase ticks in the cycles after the start edge, up to and including the cycle of the following stop edge. With the internal timebase, edges D clocks apart give D.
- R3: The second separation counts ticks from the last stop edge to the next start edge. It is reported when that start edge arrives.
- R4: A further start edge that arrives while the block waits for a stop edge restarts the first separation from zero.
- R5: If both inputs rise in the same cycle while a stop edge is awaited, the first separation is 0. If this happens during a second-separation interval, that second separation and a first separation of 0 are reported together in one result.
- R6: After enabling, stop edges seen before the first start edge produce no result.
- R7: A further stop edge that arrives during a second-separation interval restarts that interval from zero.
- R8: Counts saturate at 2^CNT_W-1. A field's overflow flag is 1 exactly when its value is pinned at that maximum.
- R9: With `cfg_ext_tb` = 1, the tick is each synchronised rising edge of `tb_ext_in` instead of each clock.
- R10: Driving `cfg_enable` low abandons any interval in progress. After re-enabling, the block again waits for a start edge.
- R11: With `cfg_buffered` = 0, each result updates the matching `reg_*` field and `m_valid` stays 0.
- R12: With `cfg_buffered` = 1, a beat stays valid and unchanged while `m_ready` is 0. A new result arriving in that time overwrites only the field it carries and sets that field's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | 1 = measure, 0 = idle |
| cfg_buffered | input | 1 | 1 = stream output, 0 = register output |
| cfg_ext_tb | input | 1 | 1 = count external timebase edges |
| start_in | input | 1 | Asynchronous first signal |
| stop_in | input | 1 | Asynchronous second signal |
| tb_ext_in | input | 1 | Asynchronous external timebase |
| reg_first | output | CNT_W | Last first separation (single mode) |
| reg_first_ovf | output | 1 | Overflow flag of `reg_first` |
| reg_second | output | CNT_W | Last second separation (single mode) |
| reg_second_ovf | output | 1 | Overflow flag of `reg_second` |
| m_valid | output | 1 | Stream beat valid |
| m_ready | input | 1 | Stream beat accepted |
| m_first_vld | output | 1 | Beat carries a first separation |
| m_first | output | CNT_W | First separation of the beat |
| m_first_ovf | output | 1 | Overflow flag of `m_first` |
| m_second_vld | output | 1 | Beat carries a second separation |
| m_second | output | CNT_W | Second separation of the beat |
| m_second_ovf | output | 1 | Overflow flag of `m_second` |

## Verification
Closing a second-separation interval and closing a first-separation interval can fall in the same cycle. This happens when both inputs rise together while the reverse interval is running. The bench provokes it by driving `start_in` and `stop_in` high in one cycle, just after a stop edge. It then expects one beat that carries the second separation together with a first separation of 0. A second tie, driven while a stop edge is awaited, must yield a beat that holds only a first separation of 0. A result arriving while the stream is stalled is another same-cycle meeting: a pending beat and a fresh result. This is judged by checking that only the carried field is replaced in the held beat.

// File: rtl/tse_pkg.sv
// Shared types for the two-edge separation timer.
package tse_pkg;

    // Measurement state: off, waiting for a start edge,
    // timing start-to-stop, timing stop-to-start.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_A   = 2'd1,
        ST_COUNT_AB = 2'd2,
        ST_COUNT_BA = 2'd3
    } sep_state_e;

endpackage

// File: rtl/tse_edge_sync.sv
// Synchroniser plus rising-edge detector.
// Brings one asynchronous level into the clock domain through STAGES flops.
// Then emits a one-cycle pulse on each rising edge of the synchronised level.
// Assumes: the input stays high and low each for at least one clock,
// so that every edge is seen.
module tse_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES > 1) begin : g_multi
            // Purpose: shift the raw level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], din};
            end
        end else begin : g_single
            // Purpose: single-flop capture when only one stage is asked for.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end
    endgenerate

    // Purpose: remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tse_timebase.sv
// Timebase selector.
// Gives one tick per clock, or one tick per synchronised rising edge
// of the external timebase pin.
// Assumes: the external timebase runs below half the clock rate.
// Uses the same synchroniser depth as the signal inputs,
// so both paths have the same latency.
module tse_timebase #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_ext,
    input  logic tb_pin,
    output logic tick
);

    logic ext_rise;

    tse_edge_sync #(.STAGES(STAGES)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tb_pin),
        .rise (ext_rise)
    );

    // Purpose: choose the tick source.
    always_comb begin
        tick = use_ext ? ext_rise : 1'b1;
    end

endmodule

// File: rtl/tse_sep_core.sv
// Separation measurement engine.
// Holds the arm/measure state machine and two saturating counters:
//   - start-to-stop for the first separation;
//   - stop-to-start for the second separation.
// A result counts the ticks after the opening edge up to and including
// the closing cycle, so a tie yields 0.
// Results leave as registered one-cycle pulses.
// Assumes: rise_start, rise_stop and tick are one-cycle pulses
// in the clock domain.
module tse_sep_core
    import tse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rise_start,
    input  logic             rise_stop,
    input  logic             tick,
    output sep_state_e       state_o,
    output logic             first_vld,
    output logic [CNT_W-1:0] first_val,
    output logic             first_ovf,
    output logic             second_vld,
    output logic [CNT_W-1:0] second_val,
    output logic             second_ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    sep_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_ab_q, cnt_ab_d, cnt_ba_q, cnt_ba_d;
    logic [CNT_W-1:0] ab_step, ba_step;
    logic             f_v, s_v;
    logic [CNT_W-1:0] f_val, s_val;

    function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c,
                                                   input logic t);
        return (c == CNT_MAX) ? CNT_MAX : c + CNT_W'(t);
    endfunction

    // Purpose: counter values that include this cycle's tick.
    always_comb begin
        ab_step = sat_step(cnt_ab_q, tick);
        ba_step = sat_step(cnt_ba_q, tick);
    end

    // Purpose: next state, counter updates and result selection.
    always_comb begin
        state_d  = state_q;
        cnt_ab_d = ab_step;
        cnt_ba_d = ba_step;
        f_v      = 1'b0;
        f_val    = '0;
        s_v      = 1'b0;
        s_val    = '0;
        if (!enable) begin
            state_d  = ST_IDLE;
            cnt_ab_d = '0;
            cnt_ba_d = '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_d  = ST_WAIT_A;
                    cnt_ab_d = '0;
                    cnt_ba_d = '0;
                end
                ST_WAIT_A: begin
                    cnt_ab_d = '0;
                    cnt_ba_d = '0;
                    if (rise_start && rise_stop) begin
                        f_v     = 1'b1;
                        state_d = ST_COUNT_BA;
                    end else if (rise_start) begin
                        state_d = ST_COUNT_AB;
                    end
                end
                ST_COUNT_AB: begin
                    if (rise_stop) begin
                        f_v      = 1'b1;
                        f_val    = rise_start ? '0 : ab_step;
                        state_d  = ST_COUNT_BA;
                        cnt_ba_d = '0;
                    end else if (rise_start) begin
                        cnt_ab_d = '0;
                    end
                end
                ST_COUNT_BA: begin
                    if (rise_start) begin
                        s_v   = 1'b1;
                        s_val = ba_step;
                        if (rise_stop) begin
                            f_v      = 1'b1;
                            cnt_ba_d = '0;
                        end else begin
                            state_d  = ST_COUNT_AB;
                            cnt_ab_d = '0;
                        end
                    end else if (rise_stop) begin
                        cnt_ba_d = '0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Purpose: state, counters and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_ab_q   <= '0;
            cnt_ba_q   <= '0;
            first_vld  <= 1'b0;
            first_val  <= '0;
            first_ovf  <= 1'b0;
            second_vld <= 1'b0;
            second_val <= '0;
            second_ovf <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_ab_q   <= cnt_ab_d;
            cnt_ba_q   <= cnt_ba_d;
            first_vld  <= f_v;
            first_val  <= f_val;
            first_ovf  <= f_v && (f_val == CNT_MAX);
            second_vld <= s_v;
            second_val <= s_val;
            second_ovf <= s_v && (s_val == CNT_MAX);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/tse_result_out.sv
// Result delivery.
// In single mode, results land in the readable result registers.
// In buffered mode, they form a one-register valid/ready beat.
// If the beat is stalled, a new result replaces only the field it carries.
// Assumes: the mode changes only while the block is idle.
module tse_result_out #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buffered,
    input  logic             in_first_vld,
    input  logic [CNT_W-1:0] in_first,
    input  logic             in_first_ovf,
    input  logic             in_second_vld,
    input  logic [CNT_W-1:0] in_second,
    input  logic             in_second_ovf,
    output logic [CNT_W-1:0] reg_first,
    output logic             reg_first_ovf,
    output logic [CNT_W-1:0] reg_second,
    output logic             reg_second_ovf,
    output logic             m_valid,
    input  logic             m_ready,
    output logic             m_first_vld,
    output logic [CNT_W-1:0] m_first,
    output logic             m_first_ovf,
    output logic             m_second_vld,
    output logic [CNT_W-1:0] m_second,
    output logic             m_second_ovf
);

    logic fresh, taken, open_slot;

    // Purpose: decode new-result and handshake conditions.
    always_comb begin
        fresh     = in_first_vld | in_second_vld;
        taken     = m_valid & m_ready;
        open_slot = ~m_valid | taken;
    end

    // Purpose: result registers for single mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_first      <= '0;
            reg_first_ovf  <= 1'b0;
            reg_second     <= '0;
            reg_second_ovf <= 1'b0;
        end else if (!buffered) begin
            if (in_first_vld) begin
                reg_first     <= in_first;
                reg_first_ovf <= in_first_ovf;
            end
            if (in_second_vld) begin
                reg_second     <= in_second;
                reg_second_ovf <= in_second_ovf;
            end
        end
    end

    // Purpose: stream beat register with merge-on-stall.
    always_ff @(posedge clk) begin
        if (!rst_n || !buffered) begin
            m_valid      <= 1'b0;
            m_first_vld  <= 1'b0;
            m_first      <= '0;
            m_first_ovf  <= 1'b0;
            m_second_vld <= 1'b0;
            m_second     <= '0;
            m_second_ovf <= 1'b0;
        end else if (fresh && open_slot) begin
            m_valid      <= 1'b1;
            m_first_vld  <= in_first_vld;
            m_first      <= in_first_vld ? in_first : '0;
            m_first_ovf  <= in_first_vld & in_first_ovf;
            m_second_vld <= in_second_vld;
            m_second     <= in_second_vld ? in_second : '0;
            m_second_ovf <= in_second_vld & in_second_ovf;
        end else if (fresh) begin
            if (in_first_vld) begin
                m_first_vld <= 1'b1;
                m_first     <= in_first;
                m_first_ovf <= in_first_ovf;
            end
            if (in_second_vld) begin
                m_second_vld <= 1'b1;
                m_second     <= in_second;
                m_second_ovf <= in_second_ovf;
            end
        end else if (taken) begin
            m_valid      <= 1'b0;
            m_first_vld  <= 1'b0;
            m_second_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/two_edge_sep_timer.sv
// Two-edge separation timer, top level.
// Chain: synchronised edge detectors for start and stop,
// a timebase selector, the measurement engine, and result delivery.
// Assumes: configuration inputs are in the clock domain
// and change only while cfg_enable is 0.
module two_edge_sep_timer
    import tse_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_buffered,
    input  logic             cfg_ext_tb,
    input  logic             start_in,
    input  logic             stop_in,
    input  logic             tb_ext_in,
    output logic [CNT_W-1:0] reg_first,
    output logic             reg_first_ovf,
    output logic [CNT_W-1:0] reg_second,
    output logic             reg_second_ovf,
    output logic             m_valid,
    input  logic             m_ready,
    output logic             m_first_vld,
    output logic [CNT_W-1:0] m_first,
    output logic             m_first_ovf,
    output logic             m_second_vld,
    output logic [CNT_W-1:0] m_second,
    output logic             m_second_ovf
);

    logic             rise_start, rise_stop, tick;
    sep_state_e       core_state;
    logic             core_first_vld, core_first_ovf;
    logic             core_second_vld, core_second_ovf;
    logic [CNT_W-1:0] core_first, core_second;

    tse_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(clk), .rst_n(rst_n), .din(start_in), .rise(rise_start)
    );

    tse_edge_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .din(stop_in), .rise(rise_stop)
    );

    tse_timebase #(.STAGES(SYNC_STAGES)) u_tb (
        .clk(clk), .rst_n(rst_n), .use_ext(cfg_ext_tb),
        .tb_pin(tb_ext_in), .tick(tick)
    );

    tse_sep_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .rise_start(rise_start),
        .rise_stop (rise_stop),
        .tick      (tick),
        .state_o   (core_state),
        .first_vld (core_first_vld),
        .first_val (core_first),
        .first_ovf (core_first_ovf),
        .second_vld(core_second_vld),
        .second_val(core_second),
        .second_ovf(core_second_ovf)
    );

    tse_result_out #(.CNT_W(CNT_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .buffered      (cfg_buffered),
        .in_first_vld  (core_first_vld),
        .in_first      (core_first),
        .in_first_ovf  (core_first_ovf),
        .in_second_vld (core_second_vld),
        .in_second     (core_second),
        .in_second_ovf (core_second_ovf),
        .reg_first     (reg_first),
        .reg_first_ovf (reg_first_ovf),
        .reg_second    (reg_second),
        .reg_second_ovf(reg_second_ovf),
        .m_valid       (m_valid),
        .m_ready       (m_ready),
        .m_first_vld   (m_first_vld),
        .m_first       (m_first),
        .m_first_ovf   (m_first_ovf),
        .m_second_vld  (m_second_vld),
        .m_second      (m_second),
        .m_second_ovf  (m_second_ovf)
    );

endmodule

// File: rtl/tse_checker.sv
// Property checker for two_edge_sep_timer, attached by bind.
// Observes the synchronised edges, the engine state and its result pulses,
// and the output stream and registers.
module tse_checker
    import tse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_buffered,
    input sep_state_e       state,
    input logic             rise_start,
    input logic             rise_stop,
    input logic             core_first_vld,
    input logic [CNT_W-1:0] core_first,
    input logic             core_second_vld,
    input logic             m_valid,
    input logic             m_ready,
    input logic             m_first_vld,
    input logic [CNT_W-1:0] m_first,
    input logic             m_first_ovf,
    input logic [CNT_W-1:0] reg_first,
    input logic             reg_first_ovf
);

    // R5: a tie while a stop edge is awaited gives a first separation of 0.
    p_tie_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable && state == ST_COUNT_AB && rise_start && rise_stop
        |=> core_first_vld && core_first == '0);

    // R6: a lone stop edge before any start edge gives no result.
    p_wait_ignores_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable && state == ST_WAIT_A && rise_stop && !rise_start
        |=> !core_first_vld);

    // R10: while disabled, the engine produces nothing.
    p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !core_first_vld && !core_second_vld);

    // R12: a stalled beat stays valid.
    p_beat_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_buffered && m_valid && !m_ready |=> m_valid);

    // R12: a stalled beat keeps its first field unless a new one arrives.
    p_first_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_buffered && m_valid && !m_ready && !core_first_vld
        |=> $stable(m_first) && $stable(m_first_vld));

    // R11: single mode keeps the stream silent.
    p_quiet_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_buffered |=> !m_valid);

    // R8: an overflow flag on the stream means the value is pinned at max.
    p_ovf_pinned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_first_vld && m_first_ovf |-> &m_first);

    // R8: the same holds for the single-mode register.
    p_reg_ovf_pinned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_first_ovf |-> &reg_first);

endmodule

bind two_edge_sep_timer tse_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_buffered   (cfg_buffered),
    .state          (core_state),
    .rise_start     (rise_start),
    .rise_stop      (rise_stop),
    .core_first_vld (core_first_vld),
    .core_first     (core_first),
    .core_second_vld(core_second_vld),
    .m_valid        (m_valid),
    .m_ready        (m_ready),
    .m_first_vld    (m_first_vld),
    .m_first        (m_first),
    .m_first_ovf    (m_first_ovf),
    .reg_first      (reg_first),
    .reg_first_ovf  (reg_first_ovf)
);

// File: tb/tb_two_edge_sep_timer.sv
// Scoreboard bench.
// The stimulus pushes expected beats into a queue,
// and a monitor pops and compares each accepted beat.
module tb_two_edge_sep_timer;

    localparam int W   = 8;
    localparam int MAX = 255;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_enable = 1'b0, cfg_buffered = 1'b1, cfg_ext_tb = 1'b0;
    logic         start_in = 1'b0, stop_in = 1'b0, tb_ext_in = 1'b0;
    logic         m_ready = 1'b1;
    logic [W-1:0] reg_first, reg_second, m_first, m_second;
    logic         reg_first_ovf, reg_second_ovf, m_valid;
    logic         m_first_vld, m_first_ovf, m_second_vld, m_second_ovf;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        bit    fv;
        int    f;
        bit    sv;
        int    s;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    two_edge_sep_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_buffered(cfg_buffered), .cfg_ext_tb(cfg_ext_tb),
        .start_in(start_in), .stop_in(stop_in), .tb_ext_in(tb_ext_in),
        .reg_first(reg_first), .reg_first_ovf(reg_first_ovf),
        .reg_second(reg_second), .reg_second_ovf(reg_second_ovf),
        .m_valid(m_valid), .m_ready(m_ready),
        .m_first_vld(m_first_vld), .m_first(m_first), .m_first_ovf(m_first_ovf),
        .m_second_vld(m_second_vld), .m_second(m_second), .m_second_ovf(m_second_ovf)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic push(input bit fv, input int f, input bit sv, input int s,
                        input string tag);
        exp_t e;
        e.fv = fv; e.f = f; e.sv = sv; e.s = s; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // One driven cycle. Inputs change 5 ns after the rising edge.
    // The external timebase rises on every cycle index that is a multiple of 6.
    task automatic drive(input logic a, input logic b);
        @(posedge clk);
        #5;
        start_in  = a;
        stop_in   = b;
        tb_ext_in = ((cyc % 6) < 3);
        cyc++;
    endtask

    task automatic ev(input logic a, input logic b, input int n);
        drive(a, b);
        repeat (n - 1) drive(1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) drive(1'b0, 1'b0);
    endtask

    function automatic int ext_ticks(input int lo, input int hi);
        int n = 0;
        for (int c = lo + 1; c <= hi; c++) if (c % 6 == 0) n++;
        return n;
    endfunction

    // Monitor: compare every accepted beat with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected beat, first", int'(m_first), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(m_first_vld == e.fv, e.tag, "first flag", int'(m_first_vld), int'(e.fv));
                check(m_second_vld == e.sv, e.tag, "second flag", int'(m_second_vld), int'(e.sv));
                if (e.fv) begin
                    check(int'(m_first) == e.f, e.tag, "first value", int'(m_first), e.f);
                    check(m_first_ovf == (e.f == MAX), e.tag, "first ovf (R8)",
                          int'(m_first_ovf), int'(e.f == MAX));
                end
                if (e.sv) begin
                    check(int'(m_second) == e.s, e.tag, "second value", int'(m_second), e.s);
                    check(m_second_ovf == (e.s == MAX), e.tag, "second ovf (R8)",
                          int'(m_second_ovf), int'(e.s == MAX));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(posedge clk);
        #5 rst_n = 1'b1;
        @(negedge clk);
        check(m_valid == 1'b0, "R11", "reset m_valid", int'(m_valid), 0);
        check(reg_first == '0, "R11", "reset reg_first", int'(reg_first), 0);
        check(reg_second == '0, "R11", "reset reg_second", int'(reg_second), 0);

        // Phase 1: internal timebase, buffered, R1..R5, R7.
        push(1, 10, 0, 0, "R2");
        push(0, 0, 1, 7, "R3");
        push(1, 5, 0, 0, "R2");
        push(0, 0, 1, 6, "R7");
        push(1, 9, 0, 0, "R4");
        push(1, 0, 1, 5, "R5");
        push(0, 0, 1, 8, "R3");
        push(1, 0, 0, 0, "R5");
        push(0, 0, 1, 6, "R3");
        push(1, 8, 0, 0, "R1");
        cfg_enable = 1'b1;
        idle(5);
        ev(1, 0, 10);
        ev(0, 1, 7);
        ev(1, 0, 5);
        ev(0, 1, 20);
        ev(0, 1, 6);     // extra stop restarts the second interval (R7)
        ev(1, 0, 4);
        ev(1, 0, 9);     // extra start restarts the first interval (R4)
        ev(0, 1, 5);
        ev(1, 1, 8);     // tie during the second interval (R5)
        ev(1, 0, 6);
        ev(1, 1, 6);     // tie while a stop edge is awaited (R5)
        ev(1, 0, 5);
        repeat (5) drive(1'b1, 1'b0);   // held start level (R1)
        idle(3);
        ev(0, 1, 10);
        cfg_enable = 1'b0;
        idle(4);

        // Phase 2: abandon and re-arm (R10, R6), saturation (R8).
        cfg_enable = 1'b1;
        idle(5);
        ev(1, 0, 5);
        cfg_enable = 1'b0;
        idle(3);
        cfg_enable = 1'b1;
        idle(5);
        ev(0, 1, 6);     // must be ignored
        check(m_valid == 1'b0, "R10", "no beat after re-arm", int'(m_valid), 0);
        push(1, MAX, 0, 0, "R8");
        push(0, 0, 1, 254, "R8");
        push(1, MAX, 0, 0, "R8");
        ev(1, 0, 300);
        ev(0, 1, 254);
        ev(1, 0, 255);
        ev(0, 1, 20);
        cfg_enable = 1'b0;
        idle(4);

        // Phase 3: back-pressure and merge (R12).
        m_ready = 1'b0;
        cfg_enable = 1'b1;
        idle(5);
        ev(1, 0, 12);
        ev(0, 1, 6);
        check(m_valid && m_first_vld && !m_second_vld, "R12", "pending beat flags",
              int'({m_valid, m_first_vld, m_second_vld}), 6);
        check(int'(m_first) == 12, "R12", "pending first", int'(m_first), 12);
        ev(1, 0, 9);
        ev(0, 1, 6);
        check(int'(m_first) == 9, "R12", "overwritten first", int'(m_first), 9);
        check(int'(m_second) == 6 && m_second_vld, "R12", "merged second",
              int'(m_second), 6);
        push(1, 9, 1, 6, "R12");
        m_ready = 1'b1;
        idle(5);
        cfg_enable = 1'b0;
        idle(4);

        // Phase 4: external timebase (R9).
        cfg_ext_tb = 1'b1;
        cfg_enable = 1'b1;
        idle(6);
        c0 = cyc;
        push(1, ext_ticks(c0, c0 + 17), 0, 0, "R9");
        push(0, 0, 1, ext_ticks(c0 + 17, c0 + 27), "R9");
        push(1, ext_ticks(c0 + 27, c0 + 33), 0, 0, "R9");
        ev(1, 0, 17);
        ev(0, 1, 10);
        ev(1, 0, 6);
        ev(0, 1, 8);
        cfg_enable = 1'b0;
        idle(4);

        // Phase 5: single mode (R11).
        cfg_ext_tb = 1'b0;
        cfg_buffered = 1'b0;
        cfg_enable = 1'b1;
        idle(5);
        ev(1, 0, 15);
        ev(0, 1, 6);
        check(int'(reg_first) == 15 && !reg_first_ovf, "R11", "reg_first",
              int'(reg_first), 15);
        check(m_valid == 1'b0, "R11", "stream silent", int'(m_valid), 0);
        ev(1, 0, 6);
        check(int'(reg_second) == 6 && !reg_second_ovf, "R11", "reg_second",
              int'(reg_second), 6);
        idle(4);

        check(exp_q.size() == 0, "R2", "all expected beats seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule